// File: doc/BRIEF.md
# Bus Master FIFO Wait-State Controller

This block connects a processor core to the data side of a parallel bus master port. It contains two queues. The outbound queue carries words that the core writes towards the bus. The inbound queue carries words that the bus delivers towards the core. The block does not stall on plain empty or full conditions. Instead it looks one word ahead. When the next data phase could not be completed, it raises a registered master-wait flag and holds initiator-ready low, which stretches the current data phase.

The core has three controls. A wait-disable control turns the stalling off. A termination request lets the phase in progress complete even while waiting, and marks that beat as the last one, so a burst can be stopped after an exact number of words. A transmit-request flag tells the core that the outbound queue has room, and it is gated into an interrupt request and a DMA request.

Resets come in three forms:
- A hardware reset, which is asynchronous and active low.
- A software reset, which is a one-cycle synchronous pulse.
- A held soft-reset state.

All three flush both queues and clear the wait flag. The hardware and software resets leave the transmit request set. The held state forces it to zero.

Top module: `mstr_wait_ctrl`

## Requirements
- R1: With `xfer_dir`=1 (bus write, outbound), `mwait` is 1 after a clock edge exactly when the outbound queue holds one word after that edge. It rises on the same edge that brings the occupancy to one and falls on the edge that moves it away.
- R2: With `xfer_dir`=0 (bus read, inbound), `mwait` is 1 after a clock edge exactly when the inbound queue has one free slot after that edge.
- R3: While `mwait`=1, `wait_dis`=0 and no termination is pending, `irdy` is 0 and no word moves on the bus.
- R4: With `wait_dis`=1, `mwait` never holds `irdy` low.
- R5: `irdy` is 0 in each of these cases:
  - `xfer_active`=0;
  - a write with the outbound queue empty;
  - a read with the inbound queue full;
  - any cycle with `sw_rst` or `soft_hold` high.
  A word moves on a cycle with `irdy`=1 and `tgt_rdy`=1, which is reported on `beat`.
- R6: A `term_set` pulse makes a termination pending from the next cycle. While it is pending, `irdy` ignores the wait stall. The next beat is flagged on `last_beat`, and the pending state clears after that beat.
- R7: `treq` is 1 when the outbound queue is not full and 0 when core writes have filled it. It returns to 1 on the edge where a word leaves a full queue.
- R8: `tx_irq` is `treq` AND `tx_ie`. `tx_dma_req` is `treq` AND `tx_dma_en`.
- R9: After a hardware reset or a `sw_rst` pulse, both queues are empty, `mwait`=0 and `treq`=1.
- R10: While `soft_hold` is high, `treq` and `mwait` read 0. On release, both queues are empty and `treq` returns to 1.
- R11: A core write to a full outbound queue is dropped. Outbound words reach `bus_dout` oldest first.
- R12: Words accepted from `bus_din` on read beats reach `core_rdata` in arrival order. `core_rvalid` is 1 while the inbound queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset pulse |
| soft_hold | input | 1 | Held soft-reset state |
| wait_dis | input | 1 | Disables wait-state insertion |
| tx_ie | input | 1 | Transmit interrupt enable |
| tx_dma_en | input | 1 | Transmit DMA enable |
| term_set | input | 1 | Core termination request pulse |
| core_wr | input | 1 | Core write strobe into the outbound queue |
| core_wdata | input | 24 | Core write data |
| core_rd | input | 1 | Core read strobe from the inbound queue |
| core_rdata | output | 24 | Oldest inbound word |
| core_rvalid | output | 1 | Inbound queue not empty |
| xfer_active | input | 1 | A bus transaction is underway or requested |
| xfer_dir | input | 1 | 1 = bus write (outbound), 0 = bus read (inbound) |
| tgt_rdy | input | 1 | Target ready |
| bus_din | input | 24 | Data arriving from the bus |
| bus_dout | output | 24 | Oldest outbound word driven to the bus |
| irdy | output | 1 | Initiator ready |
| beat | output | 1 | A word moves this cycle |
| last_beat | output | 1 | This beat ends the transaction |
| mwait | output | 1 | Master-wait flag |
| treq | output | 1 | Transmit-request flag |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The bench drains a full outbound queue down to one word. A design that tested for empty instead of one remaining word would send that last word out rather than stall. It then sets `wait_dis` to release the stalled word, and sets the termination bit while stalled. A design that let the stall override termination would hang with `irdy` low. A design that failed to clear the pending termination would let the following lone word slip through. It fills the inbound queue to one free slot and then to full. A lagging flag would admit one word too many at the threshold, and a wrapped pointer would reorder the words read back by the core. A write into a full queue, and the soft-reset hold, are checked for a corrupted occupancy or a transmit request that stays raised.

// File: rtl/mwc_pkg.sv
package mwc_pkg;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } xfer_dir_e;

  // Circular pointer advance for any depth, power of two or not.
  function automatic int unsigned ptr_advance(input int unsigned ptr,
                                              input int unsigned depth);
    return (ptr + 1 == depth) ? 0 : ptr + 1;
  endfunction

  // Occupancy after one cycle of accepted pushes and pops.
  function automatic int unsigned occ_after(input int unsigned occ,
                                            input logic push,
                                            input logic pop);
    return occ + int'(push) - int'(pop);
  endfunction

  // Outbound look-ahead: one word left.
  function automatic logic one_word_left(input int unsigned occ);
    return occ == 1;
  endfunction

  // Inbound look-ahead: one free slot left.
  function automatic logic one_slot_left(input int unsigned occ,
                                         input int unsigned depth);
    return occ + 1 == depth;
  endfunction

endpackage

// File: rtl/mwc_fifo.sv
module mwc_fifo #(
  parameter int unsigned W     = 24,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] occ_nxt,
  output logic          is_full,
  output logic          is_empty
);
  import mwc_pkg::*;

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign is_full  = (occ == CW'(DEPTH));
  assign is_empty = (occ == '0);
  assign push_ok  = push && !is_full && !flush;
  assign pop_ok   = pop && !is_empty && !flush;
  assign head     = store[rd_ptr];

  always_comb begin
    if (flush) occ_nxt = '0;
    else       occ_nxt = CW'(occ_after(int'(occ), push_ok, pop_ok));
  end

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      occ <= occ_nxt;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_ok) wr_ptr <= PW'(ptr_advance(int'(wr_ptr), DEPTH));
        if (pop_ok)  rd_ptr <= PW'(ptr_advance(int'(rd_ptr), DEPTH));
      end
    end
  end

endmodule

// File: rtl/mwc_flags.sv
module mwc_flags #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          soft_hold,
  input  logic          dir_tx,
  input  logic [CW-1:0] tx_occ_nxt,
  input  logic [CW-1:0] rx_occ_nxt,
  output logic          mwait,
  output logic          treq
);
  import mwc_pkg::*;

  logic wait_nxt;
  logic room_nxt;

  always_comb begin
    if (dir_tx) wait_nxt = one_word_left(int'(tx_occ_nxt));
    else        wait_nxt = one_slot_left(int'(rx_occ_nxt), DEPTH);
    room_nxt = (tx_occ_nxt != CW'(DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mwait <= 1'b0;
      treq  <= 1'b1;
    end else if (soft_hold) begin
      mwait <= 1'b0;
      treq  <= 1'b0;
    end else if (sw_rst) begin
      mwait <= 1'b0;
      treq  <= 1'b1;
    end else begin
      mwait <= wait_nxt;
      treq  <= room_nxt;
    end
  end

endmodule

// File: rtl/mwc_phase.sv
module mwc_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic xfer_active,
  input  logic dir_tx,
  input  logic tx_empty,
  input  logic rx_full,
  input  logic mwait,
  input  logic wait_dis,
  input  logic term_set,
  input  logic tgt_rdy,
  output logic term_pend,
  output logic irdy,
  output logic beat,
  output logic last_beat
);
  logic data_ok;
  logic stall;

  assign data_ok   = dir_tx ? !tx_empty : !rx_full;
  assign stall     = mwait && !wait_dis && !term_pend;
  assign irdy      = xfer_active && data_ok && !stall && !flush;
  assign beat      = irdy && tgt_rdy;
  assign last_beat = beat && term_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          term_pend <= 1'b0;
    else if (flush)      term_pend <= 1'b0;
    else if (term_set)   term_pend <= 1'b1;
    else if (last_beat)  term_pend <= 1'b0;
  end

endmodule

// File: rtl/mstr_wait_ctrl.sv
module mstr_wait_ctrl #(
  parameter int unsigned DW    = 24,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          soft_hold,
  input  logic          wait_dis,
  input  logic          tx_ie,
  input  logic          tx_dma_en,
  input  logic          term_set,
  input  logic          core_wr,
  input  logic [DW-1:0] core_wdata,
  input  logic          core_rd,
  output logic [DW-1:0] core_rdata,
  output logic          core_rvalid,
  input  logic          xfer_active,
  input  logic          xfer_dir,
  input  logic          tgt_rdy,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          irdy,
  output logic          beat,
  output logic          last_beat,
  output logic          mwait,
  output logic          treq,
  output logic          tx_irq,
  output logic          tx_dma_req
);
  import mwc_pkg::*;

  logic          flush;
  logic          dir_tx;
  logic          term_pend;
  logic [CW-1:0] tx_occ, tx_occ_nxt, rx_occ, rx_occ_nxt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_pop, rx_push;

  assign flush   = sw_rst || soft_hold;
  assign dir_tx  = (xfer_dir_e'(xfer_dir) == DIR_TX);
  assign tx_pop  = beat && dir_tx;
  assign rx_push = beat && !dir_tx;

  mwc_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(core_wr), .push_data(core_wdata), .pop(tx_pop),
    .head(bus_dout), .occ(tx_occ), .occ_nxt(tx_occ_nxt),
    .is_full(tx_full), .is_empty(tx_empty)
  );

  mwc_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_push), .push_data(bus_din), .pop(core_rd),
    .head(core_rdata), .occ(rx_occ), .occ_nxt(rx_occ_nxt),
    .is_full(rx_full), .is_empty(rx_empty)
  );

  mwc_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .soft_hold(soft_hold),
    .dir_tx(dir_tx), .tx_occ_nxt(tx_occ_nxt), .rx_occ_nxt(rx_occ_nxt),
    .mwait(mwait), .treq(treq)
  );

  mwc_phase u_phase (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .xfer_active(xfer_active), .dir_tx(dir_tx),
    .tx_empty(tx_empty), .rx_full(rx_full),
    .mwait(mwait), .wait_dis(wait_dis), .term_set(term_set),
    .tgt_rdy(tgt_rdy), .term_pend(term_pend),
    .irdy(irdy), .beat(beat), .last_beat(last_beat)
  );

  assign core_rvalid = !rx_empty;
  assign tx_irq      = treq && tx_ie;
  assign tx_dma_req  = treq && tx_dma_en;

  // The inbound full flag is only used via the phase logic; the outbound
  // full flag is observed through occupancy by the flag logic.
  logic unused_ok;
  assign unused_ok = tx_full;

endmodule

// File: rtl/mwc_chk.sv
module mwc_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_rst,
  input logic          soft_hold,
  input logic          wait_dis,
  input logic          term_set,
  input logic          xfer_dir,
  input logic          irdy,
  input logic          beat,
  input logic          last_beat,
  input logic          mwait,
  input logic          treq,
  input logic          tx_irq,
  input logic          tx_dma_req,
  input logic          term_pend,
  input logic [CW-1:0] tx_occ,
  input logic [CW-1:0] rx_occ
);

  // R1
  tx_lookahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(xfer_dir) |-> (mwait == (tx_occ == CW'(1))));

  // R2
  rx_lookahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(xfer_dir) |-> (mwait == (rx_occ == CW'(DEPTH - 1))));

  // R3
  stall_holds_irdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mwait && !wait_dis && !term_pend) |-> !irdy);

  // R5
  no_empty_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && xfer_dir) |-> (tx_occ != '0));

  // R5
  no_full_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !xfer_dir) |-> (rx_occ != CW'(DEPTH)));

  // R6
  term_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !term_set && !sw_rst && !soft_hold) |=> !term_pend);

  // R7
  treq_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(soft_hold) |-> (treq == (tx_occ != CW'(DEPTH))));

  // R8
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq || tx_dma_req) |-> treq);

  // R9
  sw_rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rst && !soft_hold) |=> (!mwait && treq && tx_occ == '0 && rx_occ == '0));

  // R10
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_hold |=> (!treq && !mwait));

endmodule

bind mstr_wait_ctrl mwc_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (.*);

// File: tb/mstr_wait_ctrl_bench.sv
`timescale 1ns/1ps
module mstr_wait_ctrl_bench;
  localparam int DW = 24;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rst = 0, soft_hold = 0, wait_dis = 0, tx_ie = 0, tx_dma_en = 0;
  logic term_set = 0, core_wr = 0, core_rd = 0;
  logic xfer_active = 0, xfer_dir = 1, tgt_rdy = 0;
  logic [DW-1:0] core_wdata = '0, bus_din = '0;
  logic [DW-1:0] core_rdata, bus_dout;
  logic core_rvalid, irdy, beat, last_beat, mwait, treq, tx_irq, tx_dma_req;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mstr_wait_ctrl u_mstr_wait_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .soft_hold(soft_hold),
    .wait_dis(wait_dis), .tx_ie(tx_ie), .tx_dma_en(tx_dma_en),
    .term_set(term_set), .core_wr(core_wr), .core_wdata(core_wdata),
    .core_rd(core_rd), .core_rdata(core_rdata), .core_rvalid(core_rvalid),
    .xfer_active(xfer_active), .xfer_dir(xfer_dir), .tgt_rdy(tgt_rdy),
    .bus_din(bus_din), .bus_dout(bus_dout), .irdy(irdy), .beat(beat),
    .last_beat(last_beat), .mwait(mwait), .treq(treq), .tx_irq(tx_irq),
    .tx_dma_req(tx_dma_req)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_word(input logic [DW-1:0] d);
    core_wr = 1'b1;
    core_wdata = d;
    step();
    core_wr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R9", "mwait after reset", mwait, 0);
    check("R9", "treq after reset", treq, 1);
    check("R9", "inbound empty after reset", core_rvalid, 0);
    check("R5", "irdy idle", irdy, 0);
  endtask

  task automatic t_fill();
    xfer_dir = 1'b1;
    tx_ie = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      push_word(DW'(32'h100 + i));
      check("R1", "mwait while filling", mwait, (i == 0) ? 1 : 0);
      check("R7", "treq while filling", treq, (i == DEPTH - 1) ? 0 : 1);
      check("R8", "tx_irq follows treq", tx_irq, (i == DEPTH - 1) ? 0 : 1);
      check("R5", "irdy without transaction", irdy, 0);
    end
    push_word(DW'(32'hBAD));
    check("R11", "treq stays low after dropped write", treq, 0);
  endtask

  task automatic t_drain_wait();
    wait_dis = 1'b0;
    tgt_rdy = 1'b1;
    xfer_active = 1'b1;
    #1;
    for (int k = 0; k < DEPTH - 1; k++) begin
      check("R11", "irdy while draining", irdy, 1);
      check("R11", "outbound order", bus_dout, 32'h100 + k);
      step();
      if (k == 0) check("R7", "treq back after first word leaves", treq, 1);
    end
    check("R1", "mwait at one word left", mwait, 1);
    check("R3", "irdy held low by wait", irdy, 0);
    repeat (3) step();
    check("R3", "irdy still held, no word lost", irdy, 0);
    check("R3", "stalled word kept", bus_dout, 32'h107);
    wait_dis = 1'b1;
    #1;
    check("R4", "irdy with wait disabled", irdy, 1);
    step();
    check("R11", "queue empty: dropped write not stored", irdy, 0);
    check("R1", "mwait off when empty", mwait, 0);
    xfer_active = 1'b0;
    wait_dis = 1'b0;
  endtask

  task automatic t_term();
    push_word(DW'(32'h300));
    xfer_active = 1'b1;
    #1;
    check("R3", "irdy stalled before termination", irdy, 0);
    term_set = 1'b1;
    step();
    term_set = 1'b0;
    #1;
    check("R6", "irdy released by termination", irdy, 1);
    check("R6", "last_beat flagged", last_beat, 1);
    check("R6", "terminating word", bus_dout, 32'h300);
    step();
    check("R6", "no further last_beat", last_beat, 0);
    push_word(DW'(32'h301));
    check("R6", "termination cleared, lone word stalls", irdy, 0);
    wait_dis = 1'b1;
    step();
    wait_dis = 1'b0;
    xfer_active = 1'b0;
  endtask

  task automatic t_read();
    xfer_dir = 1'b0;
    step();
    xfer_active = 1'b1;
    for (int k = 0; k < DEPTH - 1; k++) begin
      bus_din = DW'(32'h200 + k);
      #1;
      check("R2", "irdy while filling inbound", irdy, 1);
      step();
    end
    check("R2", "mwait at one free slot", mwait, 1);
    check("R3", "irdy held on read", irdy, 0);
    wait_dis = 1'b1;
    bus_din = DW'(32'h207);
    #1;
    check("R4", "irdy read with wait disabled", irdy, 1);
    step();
    check("R5", "irdy low when inbound full", irdy, 0);
    xfer_active = 1'b0;
    wait_dis = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      check("R12", "core_rvalid", core_rvalid, 1);
      check("R12", "inbound order", core_rdata, 32'h200 + k);
      core_rd = 1'b1;
      step();
      core_rd = 1'b0;
    end
    check("R12", "inbound drained", core_rvalid, 0);
    xfer_dir = 1'b1;
  endtask

  task automatic t_soft();
    push_word(DW'(32'h400));
    push_word(DW'(32'h401));
    soft_hold = 1'b1;
    step();
    check("R10", "treq in hold", treq, 0);
    check("R10", "tx_irq in hold", tx_irq, 0);
    step();
    check("R10", "mwait in hold", mwait, 0);
    soft_hold = 1'b0;
    step();
    check("R10", "treq after hold", treq, 1);
    xfer_active = 1'b1;
    #1;
    check("R10", "outbound flushed by hold", irdy, 0);
    xfer_active = 1'b0;
  endtask

  task automatic t_swrst();
    push_word(DW'(32'h500));
    check("R1", "mwait one word", mwait, 1);
    sw_rst = 1'b1;
    step();
    sw_rst = 1'b0;
    check("R9", "mwait after sw reset", mwait, 0);
    check("R9", "treq after sw reset", treq, 1);
    xfer_active = 1'b1;
    #1;
    check("R9", "outbound flushed by sw reset", irdy, 0);
    xfer_active = 1'b0;
  endtask

  task automatic t_dma();
    tx_dma_en = 1'b1;
    tx_ie = 1'b0;
    #1;
    check("R8", "dma request with room", tx_dma_req, 1);
    check("R8", "irq gated off", tx_irq, 0);
    for (int i = 0; i < DEPTH; i++) push_word(DW'(32'h600 + i));
    check("R8", "dma request off when full", tx_dma_req, 0);
    wait_dis = 1'b1;
    xfer_active = 1'b1;
    step();
    xfer_active = 1'b0;
    wait_dis = 1'b0;
    check("R8", "dma request after word leaves", tx_dma_req, 1);
    sw_rst = 1'b1;
    step();
    sw_rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fill();
    t_drain_wait();
    t_term();
    t_read();
    t_soft();
    t_swrst();
    t_dma();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule